// File: doc/BRIEF.md
# Serial Six-Bit Pattern Detector

This block watches a serial bit stream, one bit per clock, and flags every clock edge at which the six most recent bits form the fixed sequence 1,0,1,0,1,1. The first of these six bits is the earliest one received. The bits are held in a shift register that acts as a sliding window. One wide AND-style term compares every tap with the pattern in the same cycle, so the block needs no state machine. Taps that must be 0 enter that term inverted, and taps that must be 1 enter it directly.

The compare result reaches the pin through a chain of buffer stages. The chain is modelled as logically transparent, so the pin has the polarity and timing of the compare. The reset is asserted asynchronously and active low. Its release is resynchronised inside the block, and the window stays cleared during that release.

Top module: `seqdet_top`

## Requirements
- R1: While `rst_ni` is low, `detect_o` is low. After reset it stays low until a complete pattern has been received.
- R2: If the bits captured at six consecutive rising edges are 1,0,1,0,1,1 in arrival order, `detect_o` is high from the sixth of those edges until the next edge.
- R3: Any other six-bit history leaves `detect_o` low. This includes 001011 and the reversed order 110101.
- R4: Overlapping matches are reported. In the stream 1,0,1,0,1,1,0,1,0,1,1 the last bit of the first pattern is reused as the first bit of the second, and `detect_o` goes high after bit 6 and again after bit 11.
- R5: For this pattern a detect lasts exactly one clock cycle. Two consecutive edges can never both complete a match.
- R6: The output chain adds no inversion and no cycle of latency. `detect_o` equals the compare result in the same cycle.
- R7: Taking `rst_ni` low in the middle of a stream clears every window stage to 0. Bits received before the reset cannot complete a pattern afterwards.
- R8: After `rst_ni` rises, the window ignores `serial_i` at the first two rising edges and starts shifting at the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the window shifts on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released through a two-flop synchroniser |
| serial_i | input | 1 | Serial data bit captured on each rising edge |
| detect_o | output | 1 | High while the last six captured bits equal 1,0,1,0,1,1 |

## Verification
The bench builds the block with its default parameters: a six-bit window, the pattern 101011, a four-stage output chain and a two-stage release synchroniser. With these values it can test the real pattern: one overlapping stream, the rule that a detect never lasts two cycles, the mismatch and reversed-order cases, and the exact edges ignored after reset release. A reference window in the bench shifts the same bits and predicts `detect_o` at every edge.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  localparam int unsigned DEF_WIDTH      = 6;
  localparam logic [5:0]  DEF_PATTERN    = 6'b101011;
  localparam int unsigned DEF_BUF_STAGES = 4;
  localparam int unsigned DEF_SYNC_DEPTH = 2;

  // Tap polarity: 1 means the tap feeds the match term through an inverter.
  typedef enum logic {
    TAP_DIRECT   = 1'b0,
    TAP_INVERTED = 1'b1
  } tap_pol_e;

endpackage

// File: rtl/seqdet_rst_sync.sv
module seqdet_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[DEPTH-1];

  // The synchronised reset never releases at the edge where the raw reset was still low.
  p_sync_release_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_sync_no) |-> $past(sync_q[0]));

endmodule

// File: rtl/seqdet_window.sv
module seqdet_window #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  output logic [WIDTH-1:0] taps_o
);

  logic [WIDTH-1:0] win_q;
  logic [WIDTH-1:0] win_d;
  logic             shift_en;

  // Index 0 holds the newest bit, index WIDTH-1 the oldest.
  assign shift_en = 1'b1;

  always_comb begin
    win_d = win_q;
    if (shift_en) begin
      win_d = {win_q[WIDTH-2:0], bit_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
    end else begin
      win_q <= win_d;
    end
  end

  assign taps_o = win_q;

  p_newest_tap_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> taps_o[0] == $past(bit_i));

  p_shift_order_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> taps_o[WIDTH-1:1] == $past(taps_o[WIDTH-2:0]));

  p_reset_clear_r7 : assert property (@(posedge clk_i)
    !rst_ni |-> taps_o == '0);

endmodule

// File: rtl/seqdet_match.sv
module seqdet_match
  import seqdet_pkg::*;
#(
  parameter int unsigned     WIDTH   = DEF_WIDTH,
  parameter logic [WIDTH-1:0] PATTERN = DEF_PATTERN
) (
  input  logic [WIDTH-1:0] taps_i,
  output logic             hit_o
);

  logic [WIDTH-1:0] term;
  logic             nand_n;

  for (genvar g = 0; g < WIDTH; g++) begin : g_tap
    localparam tap_pol_e POL = PATTERN[g] ? TAP_DIRECT : TAP_INVERTED;
    if (POL == TAP_INVERTED) begin : g_inv
      assign term[g] = ~taps_i[g];
    end else begin : g_dir
      assign term[g] = taps_i[g];
    end
  end

  // Wide NAND followed by an inverter gives an active-high hit.
  assign nand_n = ~(&term);
  assign hit_o  = ~nand_n;

  always_comb begin
    if (hit_o) begin
      p_hit_newest_r3 : assert (taps_i[0] == PATTERN[0]);
    end
  end

endmodule

// File: rtl/seqdet_drive.sv
module seqdet_drive #(
  parameter int unsigned STAGES = 4
) (
  input  logic in_i,
  output logic out_o
);

  localparam bit ODD = (STAGES % 2) == 1;

  logic [STAGES:0] node;

  assign node[0] = in_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    assign node[g+1] = ~node[g];
  end

  // An odd chain would invert; a polarity fix keeps the chain transparent.
  if (ODD) begin : g_fix
    assign out_o = ~node[STAGES];
  end else begin : g_even
    assign out_o = node[STAGES];
  end

  always_comb begin
    p_transparent_r6 : assert (out_o === in_i);
  end

endmodule

// File: rtl/seqdet_top.sv
module seqdet_top
  import seqdet_pkg::*;
#(
  parameter int unsigned      WIDTH      = DEF_WIDTH,
  parameter logic [WIDTH-1:0] PATTERN    = DEF_PATTERN,
  parameter int unsigned      BUF_STAGES = DEF_BUF_STAGES,
  parameter int unsigned      SYNC_DEPTH = DEF_SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic serial_i,
  output logic detect_o
);

  // A pattern equal to itself shifted by one could match on two consecutive edges.
  localparam bit SELF_SHIFT = PATTERN[WIDTH-2:0] == PATTERN[WIDTH-1:1];

  logic             rst_sync_n;
  logic [WIDTH-1:0] taps;
  logic             hit;

  seqdet_rst_sync #(.DEPTH(SYNC_DEPTH)) u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  seqdet_window #(.WIDTH(WIDTH)) u_window (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .bit_i (serial_i),
    .taps_o(taps)
  );

  seqdet_match #(.WIDTH(WIDTH), .PATTERN(PATTERN)) u_match (
    .taps_i(taps),
    .hit_o (hit)
  );

  seqdet_drive #(.STAGES(BUF_STAGES)) u_drive (
    .in_i (hit),
    .out_o(detect_o)
  );

  p_reset_low_r1 : assert property (@(posedge clk_i)
    !rst_ni |-> !detect_o);

  p_detect_last_bit_r2 : assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $rose(detect_o) |-> $past(serial_i) == PATTERN[0]);

  if (!SELF_SHIFT) begin : g_pulse
    p_single_pulse_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      detect_o |=> !detect_o);
  end

endmodule

// File: tb/seqdet_top_tb.sv
`timescale 1ns/1ps
module seqdet_top_tb;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic serial_i;
  logic detect_o;

  int checks = 0;
  int errors = 0;
  logic [5:0] model_win;
  int         ignore_cnt;
  bit         done = 1'b0;

  localparam logic [5:0] PAT = 6'b101011;

  always #2 clk_i = ~clk_i;

  seqdet_top u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .serial_i(serial_i),
    .detect_o(detect_o)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (detect_o !== exp) begin
      errors++;
      $display("FAIL %s detect_o actual %b expected %b at %0t", req, detect_o, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni   = 1'b0;
    serial_i = 1'b0;
    model_win = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    ignore_cnt = 2;
  endtask

  // Drives one bit, lets one edge pass, then compares with the reference window.
  task automatic send_bit(input logic b, input string req);
    @(negedge clk_i);
    serial_i = b;
    @(posedge clk_i);
    if (ignore_cnt > 0) ignore_cnt--;
    else model_win = {model_win[4:0], b};
    #1;
    check(model_win == PAT, req);
  endtask

  task automatic send_seq(input logic [31:0] bits, input int n, input string req);
    for (int i = n - 1; i >= 0; i--) send_bit(bits[i], req);
  endtask

  task automatic t_reset_state();
    @(negedge clk_i);
    rst_ni = 1'b0;
    serial_i = 1'b1;
    #1 check(1'b0, "R1 during reset");
    do_reset();
    send_seq(32'b00, 2, "R8 idle");
    send_seq(32'b10101, 5, "R1 partial");
  endtask

  task automatic t_match();
    do_reset();
    send_seq(32'b00, 2, "R8 idle");
    send_seq(32'b101011, 6, "R2 match");
    check(1'b1, "R6 polarity");
  endtask

  task automatic t_mismatch();
    do_reset();
    send_seq(32'b00, 2, "R8 idle");
    send_seq(32'b001011, 6, "R3 001011");
    send_seq(32'b110101, 6, "R3 reversed");
    check(1'b0, "R3 reversed final");
  endtask

  task automatic t_overlap();
    do_reset();
    send_seq(32'b00, 2, "R8 idle");
    send_seq(32'b10101, 5, "R4 first");
    send_bit(1'b1, "R4 first hit");
    check(1'b1, "R4 first hit");
    send_seq(32'b0101, 4, "R4 second");
    send_bit(1'b1, "R4 second hit");
    check(1'b1, "R4 second hit");
  endtask

  task automatic t_pulse();
    send_bit(1'b1, "R5 pulse end");
    check(1'b0, "R5 pulse end");
    send_seq(32'b01011, 5, "R5 rematch");
    send_bit(1'b0, "R5 drop");
  endtask

  task automatic t_midreset();
    do_reset();
    send_seq(32'b00, 2, "R8 idle");
    send_seq(32'b10101, 5, "R7 prefix");
    do_reset();
    send_seq(32'b11, 2, "R7 idle");
    send_bit(1'b1, "R7 after reset");
    check(1'b0, "R7 no stale match");
  endtask

  task automatic t_release();
    do_reset();
    send_bit(1'b1, "R8 ignored edge 1");
    send_bit(1'b0, "R8 ignored edge 2");
    send_seq(32'b1011, 4, "R8 tail");
    check(1'b0, "R8 tail no match");
    send_seq(32'b01011, 5, "R8 real");
    check(1'b1, "R8 real match");
  endtask

  initial begin
    rst_ni = 1'b0;
    serial_i = 1'b0;
    model_win = '0;
    ignore_cnt = 0;
    t_reset_state();
    t_match();
    t_mismatch();
    t_overlap();
    t_pulse();
    t_midreset();
    t_release();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule